// File: doc/BRIEF.md
# Ultra DMA Receive-Burst Terminator

This block is the device-side engine for a host-to-device Ultra DMA burst. It controls the receive direction of such a burst, and its main work is pausing or ending the burst when the device asks for it. It takes host signals that are already synchronized to the device clock: the active-low acknowledge, the stop line, the strobe and the 16-bit data bus. It drives the request line and the active-low ready line. It also produces a stream of received words, the host's CRC value as latched, and a sticky CRC-error flag.

A word is taken on every strobe transition while the device is ready. When the device asks to end the burst, the engine first withdraws ready. It then keeps accepting the few words still in flight, and after a programmable gap it drops the request line. On the edge where the host releases acknowledge, it latches the host's CRC from the data bus and compares it with the running CRC supplied by the device. The polynomial itself is computed elsewhere.

Top module: `udma_rx_term`

## Requirements
- R1: Out of reset, `dmaReq` is low, `devReadyN` is high and `crcErr` is low. While idle, `dmaReq` follows `xferReq`. Once `xferReq` is high and `dmackN` has been sampled low, `devReadyN` goes low one cycle later.
- R2: While `devReadyN` is low, each change of `hostStrobe` (rising or falling) sampled at a clock edge produces `wordValid` for one cycle after that edge. `wordData` then carries `hostData` as it was at that edge.
- R3: `termReq` is ignored until at least one word of the current burst has been captured; `devReadyN` stays low.
- R4: On an accepted termination, `devReadyN` rises first. `dmaReq` falls exactly `T_RP` cycles later, and `hostStrobe` is still captured during that gap.
- R5: Trailing words after termination are limited. If the termination was sampled fewer than `T_SR` cycles after the last strobe change, at most one word is accepted. Otherwise at most two are accepted. Any further strobe changes are dropped.
- R6: While `pauseReq` is held (in the active phase), `devReadyN` is high and `dmaReq` stays high. At most three words are accepted during the pause. Releasing `pauseReq` returns `devReadyN` low and capture resumes.
- R7: After `dmaReq` has fallen, strobe changes produce no words.
- R8: `stopSeen` goes high when `hostStop` is sampled high after `dmaReq` has fallen, and clears when the next burst starts.
- R9: On the first clock where `dmackN` is sampled high after being low, `hostData` is latched into `crcHost`. One cycle later, `crcValid` pulses for one cycle.
- R10: If the latched host CRC differs from `devCrc`, `crcErr` is set. It stays set through later bursts whose CRC matches, and only `cmdStart` clears it.
- R11: Once `dmaReq` has fallen during a burst, it stays low until `dmackN` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Start of a new command; clears the sticky CRC error |
| xferReq | input | 1 | Device has room and wants a burst |
| termReq | input | 1 | Device asks to end the burst |
| pauseReq | input | 1 | Device asks to pause the burst |
| devCrc | input | DATA_W | Device's running CRC result |
| dmackN | input | 1 | Host acknowledge, active low, synchronized |
| hostStop | input | 1 | Host stop line, synchronized |
| hostStrobe | input | 1 | Host data strobe, synchronized |
| hostData | input | DATA_W | Host data bus, synchronized |
| dmaReq | output | 1 | Request line to host |
| devReadyN | output | 1 | Device ready, active low |
| stopSeen | output | 1 | Host stop confirmed during termination |
| wordValid | output | 1 | Received word strobe |
| wordData | output | DATA_W | Received word |
| crcHost | output | DATA_W | Host CRC latched at acknowledge release |
| crcValid | output | 1 | One-cycle pulse after the CRC compare |
| crcErr | output | 1 | Sticky CRC mismatch flag |

## Verification
The hardest condition to reach from the ports is the split between the one-word and two-word trailing limits. It depends on how many cycles separate the last strobe change from the sampled termination request. The stimulus places one strobe change, then raises `termReq` on the very next cycle for the short limit, and waits eight idle cycles for the long limit. In both cases three strobe changes are driven inside the `T_RP` gap, so that both the accepted words and the dropped words are seen by the scoreboard.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_PAUSE,
    ST_TERM_WAIT,
    ST_DRQ_NEG,
    ST_WAIT_ACK,
    ST_CHECK
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic latchCrc;
    logic checkCrc;
    logic clrErr;
  } dpCtl_t;

endpackage

// File: rtl/udma_rx_ctrl.sv
module udma_rx_ctrl
  import udma_rx_pkg::*;
#(
  parameter int T_RP        = 4,
  parameter int T_SR        = 3,
  parameter int PAUSE_WORDS = 3,
  parameter int TRAIL_NEAR  = 1,
  parameter int TRAIL_FAR   = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdStart,
  input  logic   xferReq,
  input  logic   termReq,
  input  logic   pauseReq,
  input  logic   dmackN,
  input  logic   hostStop,
  input  logic   strobeEdge,
  output logic   dmaReq,
  output logic   devReadyN,
  output logic   stopSeen,
  output dpCtl_t ctl
);

  localparam int TW = (T_RP < 2) ? 1 : $clog2(T_RP);
  localparam int SW = $clog2(T_SR + 1) + 1;
  localparam int MAXX = (PAUSE_WORDS > TRAIL_FAR) ? PAUSE_WORDS : TRAIL_FAR;
  localparam int EW = $clog2(MAXX + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(T_RP - 1);
  localparam logic [SW-1:0] SR_LIM   = SW'(T_SR);
  localparam logic [EW-1:0] PAUSE_LIM = EW'(PAUSE_WORDS);
  localparam logic [EW-1:0] NEAR_LIM  = EW'(TRAIL_NEAR);
  localparam logic [EW-1:0] FAR_LIM   = EW'(TRAIL_FAR);

  rxState_t state, nextState;
  logic [TW-1:0] tmr;
  logic [SW-1:0] sinceEdge;
  logic [EW-1:0] extraCnt, extraLim;
  logic gotWord, prevAckN;
  logic capEn, ackRise, nearEdge, burstStart, enterTerm, enterPause;

  assign ackRise  = dmackN & ~prevAckN;
  assign nearEdge = strobeEdge | (sinceEdge < SR_LIM);

  always_comb begin
    capEn = 1'b0;
    unique case (state)
      ST_ACTIVE:    capEn = 1'b1;
      ST_PAUSE:     capEn = (extraCnt < PAUSE_LIM);
      ST_TERM_WAIT: capEn = (extraCnt < extraLim);
      default:      capEn = 1'b0;
    endcase
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:
        if (xferReq && !dmackN) nextState = ST_ACTIVE;
      ST_ACTIVE:
        if (ackRise) nextState = ST_CHECK;
        else if (termReq && gotWord) nextState = ST_TERM_WAIT;
        else if (pauseReq) nextState = ST_PAUSE;
      ST_PAUSE:
        if (ackRise) nextState = ST_CHECK;
        else if (!pauseReq) nextState = ST_ACTIVE;
      ST_TERM_WAIT:
        if (ackRise) nextState = ST_CHECK;
        else if (tmr == TMR_LAST) nextState = ST_DRQ_NEG;
      ST_DRQ_NEG:
        if (ackRise) nextState = ST_CHECK;
        else if (hostStop) nextState = ST_WAIT_ACK;
      ST_WAIT_ACK:
        if (ackRise) nextState = ST_CHECK;
      ST_CHECK:
        nextState = ST_IDLE;
      default:
        nextState = ST_IDLE;
    endcase
  end

  assign burstStart = (state == ST_IDLE)   && (nextState == ST_ACTIVE);
  assign enterTerm  = (state == ST_ACTIVE) && (nextState == ST_TERM_WAIT);
  assign enterPause = (state == ST_ACTIVE) && (nextState == ST_PAUSE);

  always_comb begin
    ctl.capture  = capEn & strobeEdge;
    ctl.latchCrc = ackRise & (state != ST_IDLE) & (state != ST_CHECK);
    ctl.checkCrc = (state == ST_CHECK);
    ctl.clrErr   = cmdStart;
  end

  always_comb begin
    dmaReq = 1'b0;
    unique case (state)
      ST_IDLE:                           dmaReq = xferReq;
      ST_ACTIVE, ST_PAUSE, ST_TERM_WAIT: dmaReq = 1'b1;
      default:                           dmaReq = 1'b0;
    endcase
  end

  assign devReadyN = (state != ST_ACTIVE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      sinceEdge <= SR_LIM;
      extraCnt  <= '0;
      extraLim  <= FAR_LIM;
      gotWord   <= 1'b0;
      stopSeen  <= 1'b0;
      prevAckN  <= 1'b1;
    end else begin
      state    <= nextState;
      prevAckN <= dmackN;

      if (strobeEdge)             sinceEdge <= SW'(1);
      else if (sinceEdge < SR_LIM) sinceEdge <= sinceEdge + SW'(1);

      if (state == ST_TERM_WAIT) tmr <= tmr + TW'(1);
      else                       tmr <= '0;

      if (enterTerm || enterPause || state == ST_ACTIVE)
        extraCnt <= '0;
      else if (ctl.capture)
        extraCnt <= extraCnt + EW'(1);

      if (enterTerm) extraLim <= nearEdge ? NEAR_LIM : FAR_LIM;

      if (burstStart)                                 gotWord <= 1'b0;
      else if (ctl.capture && state == ST_ACTIVE)     gotWord <= 1'b1;

      if (burstStart) stopSeen <= 1'b0;
      else if (hostStop && (state == ST_DRQ_NEG || state == ST_WAIT_ACK))
        stopSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/udma_rx_dp.sv
module udma_rx_dp
  import udma_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] devCrc,
  output logic              strobeEdge,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [DATA_W-1:0] crcHost,
  output logic              crcValid,
  output logic              crcErr
);

  logic prevStrobe;
  logic crcMiss;

  assign strobeEdge = hostStrobe ^ prevStrobe;
  assign crcMiss    = (crcHost != devCrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStrobe <= 1'b0;
      wordValid  <= 1'b0;
      wordData   <= '0;
    end else begin
      prevStrobe <= hostStrobe;
      wordValid  <= ctl.capture;
      if (ctl.capture) wordData <= hostData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcHost  <= '0;
      crcValid <= 1'b0;
      crcErr   <= 1'b0;
    end else begin
      if (ctl.latchCrc) crcHost <= hostData;
      crcValid <= ctl.checkCrc;
      if (ctl.checkCrc && crcMiss) crcErr <= 1'b1;
      else if (ctl.clrErr)         crcErr <= 1'b0;
    end
  end

endmodule

// File: rtl/udma_rx_term.sv
module udma_rx_term
  import udma_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int T_RP   = 4,
  parameter int T_SR   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              xferReq,
  input  logic              termReq,
  input  logic              pauseReq,
  input  logic [DATA_W-1:0] devCrc,
  input  logic              dmackN,
  input  logic              hostStop,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] hostData,
  output logic              dmaReq,
  output logic              devReadyN,
  output logic              stopSeen,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [DATA_W-1:0] crcHost,
  output logic              crcValid,
  output logic              crcErr
);

  dpCtl_t ctl;
  logic   strobeEdge;

  udma_rx_ctrl #(.T_RP(T_RP), .T_SR(T_SR)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .xferReq(xferReq),
    .termReq(termReq), .pauseReq(pauseReq), .dmackN(dmackN),
    .hostStop(hostStop), .strobeEdge(strobeEdge), .dmaReq(dmaReq),
    .devReadyN(devReadyN), .stopSeen(stopSeen), .ctl(ctl)
  );

  udma_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostStrobe(hostStrobe),
    .hostData(hostData), .devCrc(devCrc), .strobeEdge(strobeEdge),
    .wordValid(wordValid), .wordData(wordData), .crcHost(crcHost),
    .crcValid(crcValid), .crcErr(crcErr)
  );

endmodule

// File: rtl/udma_rx_chk.sv
module udma_rx_chk #(
  parameter int T_RP = 4
) (
  input logic clk,
  input logic rstN,
  input logic cmdStart,
  input logic dmackN,
  input logic dmaReq,
  input logic devReadyN,
  input logic wordValid,
  input logic crcValid,
  input logic crcErr
);

  logic [7:0] rdyHighCnt;
  logic [7:0] trailCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyHighCnt <= '0;
      trailCnt   <= '0;
    end else begin
      if (!devReadyN) rdyHighCnt <= '0;
      else if (rdyHighCnt != 8'hFF) rdyHighCnt <= rdyHighCnt + 8'd1;
      if (!devReadyN || dmackN) trailCnt <= '0;
      else if (wordValid && dmaReq && trailCnt != 8'hFF) trailCnt <= trailCnt + 8'd1;
    end
  end

  p_ready_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dmaReq) && !dmackN) |-> (devReadyN && rdyHighCnt >= 8'(T_RP)));

  p_trail_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    trailCnt <= 8'd4);

  p_quiet_after_drq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && !$past(dmaReq) && !dmackN) |-> !wordValid);

  p_drq_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && !dmackN) |=> !dmaReq);

  p_crc_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    crcValid |=> !crcValid);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !cmdStart) |=> crcErr);

endmodule

bind udma_rx_term udma_rx_chk #(.T_RP(T_RP)) u_chk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .dmackN(dmackN),
  .dmaReq(dmaReq), .devReadyN(devReadyN), .wordValid(wordValid),
  .crcValid(crcValid), .crcErr(crcErr)
);

// File: tb/sim_udma_rx_term.sv
module sim_udma_rx_term;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP = 3;
  localparam int T_SR = 4;
  localparam logic [15:0] GOOD_CRC = 16'hC0DE;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 0, xferReq = 0, termReq = 0, pauseReq = 0;
  logic [15:0] devCrc = GOOD_CRC;
  logic dmackN = 1, hostStop = 0, hostStrobe = 0;
  logic [15:0] hostData = '0;
  logic dmaReq, devReadyN, stopSeen, wordValid, crcValid, crcErr;
  logic [15:0] wordData, crcHost;

  int total = 0, bad = 0;
  logic [15:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  udma_rx_term #(.DATA_W(16), .T_RP(T_RP), .T_SR(T_SR)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .xferReq(xferReq),
    .termReq(termReq), .pauseReq(pauseReq), .devCrc(devCrc),
    .dmackN(dmackN), .hostStop(hostStop), .hostStrobe(hostStrobe),
    .hostData(hostData), .dmaReq(dmaReq), .devReadyN(devReadyN),
    .stopSeen(stopSeen), .wordValid(wordValid), .wordData(wordData),
    .crcHost(crcHost), .crcValid(crcValid), .crcErr(crcErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one strobe change now; expected words go to the scoreboard
  task automatic driveWord(input logic [15:0] d, input bit expect_it);
    hostData   = d;
    hostStrobe = ~hostStrobe;
    if (expect_it) expQ.push_back(d);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && wordValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R2/R5/R6/R7 unexpected word actual=%0h expected=none", wordData);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        if (wordData !== e) begin
          bad++;
          $display("FAIL R2 word actual=%0h expected=%0h", wordData, e);
        end
      end
    end
  end

  task automatic startBurst();
    @(negedge clk); xferReq = 1; dmackN = 0;
    @(negedge clk);
    chk("R1", "devReadyN after ack", devReadyN, 0);
    chk("R1", "dmaReq in burst", dmaReq, 1);
  endtask

  // termination starting now; drives three strobes in the gap
  task automatic terminate(input int nAccept, input int nStrobes, input logic [15:0] base);
    @(negedge clk); termReq = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      termReq = 0;
      if (i == 0) chk("R4", "devReadyN rises first", devReadyN, 1);
      if (i < 3) chk("R4", "dmaReq held in gap", dmaReq, 1);
      else       chk("R4", "dmaReq falls after T_RP", dmaReq, 0);
      if (i < nStrobes) driveWord(base + 16'(i), i < nAccept); // R5
      else if (i == 3) driveWord(16'hDEAD, 0);                 // R7
    end
  endtask

  task automatic finishBurst(input logic [15:0] hcrc, input logic expErr);
    @(negedge clk);
    chk("R11", "dmaReq low before ack release", dmaReq, 0);
    hostStop = 1;
    @(negedge clk);
    chk("R8", "stopSeen", stopSeen, 1);
    hostData = hcrc; dmackN = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "crcValid", crcValid, 1);
    chk("R9", "crcHost", crcHost, hcrc);
    chk("R10", "crcErr", crcErr, expErr);
    hostStop = 0;
    @(negedge clk);
    chk("R9", "crcValid one cycle", crcValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset dmaReq", dmaReq, 0);
    chk("R1", "reset devReadyN", devReadyN, 1);
    chk("R1", "reset crcErr", crcErr, 0);
    rstN = 1;
    @(negedge clk); xferReq = 1; #1;
    chk("R1", "idle dmaReq follows xferReq", dmaReq, 1);
    xferReq = 0;

    // burst 1: far termination, good CRC
    startBurst();
    termReq = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R3", "no termination before a word", devReadyN, 0);
    end
    termReq = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); driveWord(16'h1000 + 16'(i), 1);
    end
    repeat (8) @(negedge clk);
    terminate(2, 3, 16'h2000);
    finishBurst(GOOD_CRC, 0);
    chk("R11", "dmaReq back in idle", dmaReq, 1);

    // burst 2: near termination, bad CRC
    startBurst();
    driveWord(16'h3000, 1);
    terminate(1, 3, 16'h3100);
    finishBurst(16'hBEEF, 1);

    // burst 3: pause then far termination, good CRC
    startBurst();
    driveWord(16'h4000, 1);
    @(negedge clk); pauseReq = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk("R6", "devReadyN in pause", devReadyN, 1);
        chk("R6", "dmaReq in pause", dmaReq, 1);
      end
      driveWord(16'h4100 + 16'(i), i < 3);
    end
    @(negedge clk); pauseReq = 0;
    @(negedge clk);
    chk("R6", "resume after pause", devReadyN, 0);
    driveWord(16'h4200, 1);
    @(negedge clk); driveWord(16'h4201, 1);
    repeat (8) @(negedge clk);
    terminate(0, 0, 16'h0);
    finishBurst(GOOD_CRC, 1);
    chk("R8", "stopSeen held to next burst", stopSeen, 1);

    @(negedge clk); cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    chk("R10", "crcErr cleared by cmdStart", crcErr, 0);

    repeat (4) @(negedge clk);
    chk("R2", "scoreboard drained", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule